// File: doc/BRIEF.md
# Indirect-Access Event Counter Bank

The block holds a bank of 64 event counters, 24 bits each, that gather statistics from the surrounding datapath. Counters 0 to 31 belong to eight input ports, four counters per port. Counters 32 to 47 belong to four transmit links, and counters 48 to 63 belong to four receive links, again four per link. Each counter advances by one on every cycle its event pulse is high. For the first counter of each receive link, a per-link mode input chooses which event it counts: the ordinary receive event or a stuff event.

A host never addresses a counter directly. It works through a byte-wide register window. The window has a select register that names one counter, a command register, and three count-byte registers that hold a 24-bit snapshot. A read command copies the selected counter into the count-byte registers, where the value stays until the next read command. A write command loads the count-byte registers into the selected counter. Other command codes set or clear the selected counter's interrupt enable.

When a counter goes from all ones to zero, it sets a sticky overflow flag. The single interrupt output is high while any counter has both its flag and its enable set. A host can preload a counter to 2^24 - N so that the interrupt fires after N events.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset, every counter, the select register and every count-byte register read as zero, and irq_o is low.
- R2: On each clock edge where a counter's event is high and that counter is not being loaded, the counter increases by exactly one.
- R3: An event on a counter that holds 0xFFFFFF sets the counter to 0x000000 and sets that counter's sticky overflow flag.
- R4: irq_o is high exactly while some counter has its overflow flag and its interrupt enable both set. A command with low bits 011 sets the selected counter's enable, and low bits 111 clear it.
- R5: A command with bits 7, 5 and 4 at zero and low bits 101 (bits 6 and 3 ignored) copies the selected counter into the count bytes and clears that counter's overflow flag. Address 2 holds bits 7:0, address 3 holds bits 15:8 and address 4 holds bits 23:16.
- R6: The count-byte registers keep their snapshot while the counters go on counting, until the next read command or a host write to one of them.
- R7: A command with bits 7, 5 and 4 at zero and low bits 001 loads the 24-bit count-byte value into the selected counter.
- R8: When a load and an event hit the same counter in the same cycle, the counter takes the loaded value and the event is lost.
- R9: A command with bit 7, 5 or 4 set, or with low bits 000, 010, 100 or 110, changes no counter, enable, flag or count byte.
- R10: Event routing: in_ev_i[k] drives counter k, tx_ev_i[k] drives counter 32+k, and rx_ev_i[k] drives counter 48+k. For counter 48+4j, rx_stuff_mode_i[j]=1 makes it count rx_stuff_ev_i[j] in place of rx_ev_i[48+4j-48].
- R11: Register addresses: 0 is the select register (low 6 bits, read back zero-extended), 1 is the command register (reads as zero), 2 to 4 are the count bytes. A write takes effect on the clock edge where reg_we_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register address |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for reg_addr_i (combinational) |
| in_ev_i | input | 32 | Event pulses, input-port counters 0..31 |
| tx_ev_i | input | 16 | Event pulses, transmit counters 32..47 |
| rx_ev_i | input | 16 | Event pulses, receive counters 48..63 |
| rx_stuff_ev_i | input | 4 | Stuff event pulse per receive link |
| rx_stuff_mode_i | input | 4 | Per receive link: 1 = first counter counts stuff events |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
The assertions take for granted that every event input is a synchronous one-cycle-per-event level that is sampled on each clock edge. They also assume the host changes address, data and strobe only between edges, so each write lands on exactly one edge. The stimulus keeps to these rules: it drives every input one time unit after a rising edge and removes pulses after a single cycle. The one exception is the deliberate collision case, where a load command and an event are asserted together in the same cycle.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;

  localparam logic [2:0] ADDR_SEL   = 3'd0;
  localparam logic [2:0] ADDR_CMD   = 3'd1;
  localparam logic [2:0] ADDR_BYTE0 = 3'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_LOAD,
    OP_IE_SET,
    OP_IE_CLR
  } host_op_e;

  // bits 7,5,4 must be zero; bits 6,3 don't care
  function automatic host_op_e decode_cmd(input logic [7:0] c);
    host_op_e op;
    op = OP_NONE;
    if (!(c[7] || c[5] || c[4])) begin
      unique case (c[2:0])
        3'b101:  op = OP_READ;
        3'b001:  op = OP_LOAD;
        3'b011:  op = OP_IE_SET;
        3'b111:  op = OP_IE_CLR;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/stat_cnt_route.sv
module stat_cnt_route #(
  parameter int IN_PORTS = 8,
  parameter int TX_LINKS = 4,
  parameter int RX_LINKS = 4,
  parameter int PER_GRP  = 4,
  localparam int IN_W    = IN_PORTS * PER_GRP,
  localparam int TX_W    = TX_LINKS * PER_GRP,
  localparam int RX_W    = RX_LINKS * PER_GRP,
  localparam int NUM_CNT = IN_W + TX_W + RX_W
) (
  input  logic [IN_W-1:0]     in_ev_i,
  input  logic [TX_W-1:0]     tx_ev_i,
  input  logic [RX_W-1:0]     rx_ev_i,
  input  logic [RX_LINKS-1:0] rx_stuff_ev_i,
  input  logic [RX_LINKS-1:0] rx_stuff_mode_i,
  output logic [NUM_CNT-1:0]  ev_o
);

  logic [RX_W-1:0] rx_sel;

  for (genvar l = 0; l < RX_LINKS; l++) begin : g_rx_link
    for (genvar k = 0; k < PER_GRP; k++) begin : g_cnt
      if (k == 0) begin : g_mode
        assign rx_sel[l*PER_GRP+k] = rx_stuff_mode_i[l] ? rx_stuff_ev_i[l]
                                                        : rx_ev_i[l*PER_GRP+k];
      end else begin : g_plain
        assign rx_sel[l*PER_GRP+k] = rx_ev_i[l*PER_GRP+k];
      end
    end
  end

  assign ev_o = {rx_sel, tx_ev_i, in_ev_i};

endmodule

// File: rtl/stat_cnt_cell.sv
module stat_cnt_cell #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ie_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ie_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = ev_i && !ld_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      // load beats a same-cycle event
      if (ld_i)      cnt_q <= ld_val_i;
      else if (ev_i) cnt_q <= cnt_q + 1'b1;

      if (ie_set_i)      ie_q <= 1'b1;
      else if (ie_clr_i) ie_q <= 1'b0;

      // a fresh wrap survives a same-cycle clear
      flag_q <= wrap | (flag_q & ~flag_clr_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/stat_cnt_host.sv
module stat_cnt_host
  import stat_cnt_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int NUM_CNT = 64,
  localparam int NB     = CNT_W / 8,
  localparam int SEL_W  = $clog2(NUM_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] sel_cnt_i,
  output logic [SEL_W-1:0] sel_o,
  output host_op_e         op_o,
  output logic [CNT_W-1:0] snap_o,
  output logic [7:0]       rdata_o
);

  logic [SEL_W-1:0]     sel_q;
  logic [NB-1:0][7:0]   byte_q;

  assign op_o = (we_i && addr_i == ADDR_CMD) ? decode_cmd(wdata_i) : OP_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      byte_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_SEL) sel_q <= wdata_i[SEL_W-1:0];
      if (op_o == OP_READ) begin
        byte_q <= sel_cnt_i;
      end else begin
        for (int b = 0; b < NB; b++) begin
          if (we_i && addr_i == 3'(int'(ADDR_BYTE0) + b)) byte_q[b] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_SEL) rdata_o = 8'(sel_q);
    for (int b = 0; b < NB; b++) begin
      if (addr_i == 3'(int'(ADDR_BYTE0) + b)) rdata_o = byte_q[b];
    end
  end

  assign sel_o  = sel_q;
  assign snap_o = byte_q;

endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_cnt_pkg::*;
#(
  parameter int IN_PORTS = 8,
  parameter int TX_LINKS = 4,
  parameter int RX_LINKS = 4,
  parameter int PER_GRP  = 4,
  parameter int CNT_W    = 24,
  localparam int IN_W    = IN_PORTS * PER_GRP,
  localparam int TX_W    = TX_LINKS * PER_GRP,
  localparam int RX_W    = RX_LINKS * PER_GRP,
  localparam int NUM_CNT = IN_W + TX_W + RX_W,
  localparam int SEL_W   = $clog2(NUM_CNT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic [IN_W-1:0]     in_ev_i,
  input  logic [TX_W-1:0]     tx_ev_i,
  input  logic [RX_W-1:0]     rx_ev_i,
  input  logic [RX_LINKS-1:0] rx_stuff_ev_i,
  input  logic [RX_LINKS-1:0] rx_stuff_mode_i,
  output logic                irq_o
);

  logic [NUM_CNT-1:0]            ev_vec;
  logic [NUM_CNT-1:0]            ld_vec;
  logic [NUM_CNT-1:0]            ie_vec;
  logic [NUM_CNT-1:0]            flag_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0]              sel_cnt;
  logic [CNT_W-1:0]              snap;
  logic [SEL_W-1:0]              sel;
  host_op_e                      op;

  stat_cnt_route #(
    .IN_PORTS(IN_PORTS), .TX_LINKS(TX_LINKS),
    .RX_LINKS(RX_LINKS), .PER_GRP(PER_GRP)
  ) u_route (
    .in_ev_i        (in_ev_i),
    .tx_ev_i        (tx_ev_i),
    .rx_ev_i        (rx_ev_i),
    .rx_stuff_ev_i  (rx_stuff_ev_i),
    .rx_stuff_mode_i(rx_stuff_mode_i),
    .ev_o           (ev_vec)
  );

  stat_cnt_host #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .sel_cnt_i(sel_cnt),
    .sel_o    (sel),
    .op_o     (op),
    .snap_o   (snap),
    .rdata_o  (reg_rdata_o)
  );

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel == SEL_W'(i)) sel_cnt = cnt_q[i];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    assign hit       = (sel == SEL_W'(i));
    assign ld_vec[i] = hit && (op == OP_LOAD);

    stat_cnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev_vec[i]),
      .ld_i      (ld_vec[i]),
      .ld_val_i  (snap),
      .ie_set_i  (hit && (op == OP_IE_SET)),
      .ie_clr_i  (hit && (op == OP_IE_CLR)),
      .flag_clr_i(hit && (op == OP_READ)),
      .cnt_o     (cnt_q[i]),
      .ie_o      (ie_vec[i]),
      .flag_o    (flag_vec[i])
    );
  end

  assign irq_o = |(flag_vec & ie_vec);

endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk
  import stat_cnt_pkg::*;
#(
  parameter int NUM_CNT = 64,
  parameter int CNT_W   = 24,
  localparam int NB     = CNT_W / 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            reg_we_i,
  input logic [2:0]                      reg_addr_i,
  input logic [7:0]                      reg_wdata_i,
  input logic [NUM_CNT-1:0]              ev_vec,
  input logic [NUM_CNT-1:0]              ld_vec,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]                snap,
  input logic                            irq_o
);

  logic cmd_wr;
  logic byte_wr;
  assign cmd_wr  = reg_we_i && reg_addr_i == ADDR_CMD;
  assign byte_wr = reg_we_i && reg_addr_i >= ADDR_BYTE0 && reg_addr_i < 3'(int'(ADDR_BYTE0) + NB);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_vec[i] && !ld_vec[i]) |=> cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_vec[i] && !ld_vec[i]) |=> $stable(cnt_q[i]));

    assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_vec[i] && !ld_vec[i] && (&cnt_q[i])) |=> cnt_q[i] == '0);

    assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_vec[i] |=> cnt_q[i] == $past(snap));

    assert_load_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_vec[i] |-> (cmd_wr && reg_wdata_i[2:0] == 3'b001 &&
                     !reg_wdata_i[7] && !reg_wdata_i[5] && !reg_wdata_i[4]));
  end

  assert_snap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_wr && !(cmd_wr && decode_cmd(reg_wdata_i) == OP_READ)) |=> $stable(snap));

  assert_irq_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|ev_vec) ||
                     $past(cmd_wr && decode_cmd(reg_wdata_i) == OP_IE_SET));

  assert_irq_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(cmd_wr));

endmodule

bind stat_counter_bank stat_counter_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .ev_vec     (ev_vec),
  .ld_vec     (ld_vec),
  .cnt_q      (cnt_q),
  .snap       (snap),
  .irq_o      (irq_o)
);

// File: tb/tb_stat_counter_bank.sv
`timescale 1ns/1ps
module tb_stat_counter_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [31:0] in_ev = '0;
  logic [15:0] tx_ev = '0;
  logic [15:0] rx_ev = '0;
  logic [3:0]  st_ev = '0;
  logic [3:0]  st_mode = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic mon_req = 1'b0;

  typedef struct { string tag; logic [7:0] exp; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  stat_counter_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .in_ev_i(in_ev),
    .tx_ev_i(tx_ev), .rx_ev_i(rx_ev), .rx_stuff_ev_i(st_ev),
    .rx_stuff_mode_i(st_mode), .irq_o(irq)
  );

  // monitor: pops the scoreboard whenever the driver exposes a byte
  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%0d act=%02h exp=%02h", it.tag, addr, rdata, it.exp);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic peek_bytes(input logic [23:0] v, input string tag);
    for (int b = 0; b < 3; b++) begin
      exp_t it;
      addr = 3'(2 + b);
      it.tag = tag; it.exp = v[8*b +: 8];
      exp_q.push_back(it);
      mon_req = 1'b1;
      @(negedge clk); #1;
      mon_req = 1'b0;
    end
  endtask

  task automatic read_expect(input int idx, input logic [23:0] v, input string tag);
    reg_wr(3'd0, 8'(idx));
    reg_wr(3'd1, 8'h05);
    peek_bytes(v, tag);
  endtask

  task automatic preload(input int idx, input logic [23:0] v);
    reg_wr(3'd2, v[7:0]);
    reg_wr(3'd3, v[15:8]);
    reg_wr(3'd4, v[23:16]);
    reg_wr(3'd0, 8'(idx));
    reg_wr(3'd1, 8'h01);
  endtask

  // grp: 0 input port, 1 transmit, 2 receive, 3 stuff
  task automatic pulse(input int grp, input int i);
    @(posedge clk); #1;
    case (grp)
      0: in_ev[i] = 1'b1;
      1: tx_ev[i] = 1'b1;
      2: rx_ev[i] = 1'b1;
      default: st_ev[i] = 1'b1;
    endcase
    @(posedge clk); #1;
    in_ev = '0; tx_ev = '0; rx_ev = '0; st_ev = '0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    @(negedge clk);
    check(irq === e, tag, int'(irq), int'(e));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
    addr = 3'd0;
    @(negedge clk);
    check(rdata === 8'h00, "R1 select after reset", int'(rdata), 0);
    peek_bytes(24'h0, "R1 bytes after reset");
    read_expect(0, 24'h0, "R1 counter 0");
    read_expect(63, 24'h0, "R1 counter 63");

    // R11 select read-back, command reads zero
    reg_wr(3'd0, 8'd45);
    addr = 3'd0;
    @(negedge clk);
    check(rdata === 8'd45, "R11 select readback", int'(rdata), 45);
    addr = 3'd1;
    @(negedge clk);
    check(rdata === 8'h00, "R11 command reads zero", int'(rdata), 0);

    // R2 / R10 counting and routing
    repeat (3) pulse(0, 5);
    read_expect(5, 24'd3, "R2 input counter 5");
    repeat (2) pulse(1, 2);
    read_expect(34, 24'd2, "R10 tx counter 34");
    pulse(2, 1);
    read_expect(49, 24'd1, "R10 rx counter 49");
    pulse(0, 31); pulse(1, 15); pulse(2, 15);
    read_expect(31, 24'd1, "R10 counter 31");
    read_expect(47, 24'd1, "R10 counter 47");
    read_expect(63, 24'd1, "R10 counter 63");

    // R10 stuff mode on first receive counter
    pulse(3, 0);
    pulse(2, 0);
    read_expect(48, 24'd1, "R10 mode0 ignores stuff");
    st_mode[0] = 1'b1;
    pulse(2, 0);
    pulse(3, 0);
    read_expect(48, 24'd2, "R10 mode1 counts stuff");
    st_mode[0] = 1'b0;

    // R7 preload, R5 read with don't-care bits set
    preload(7, 24'h563412);
    reg_wr(3'd0, 8'd7);
    reg_wr(3'd1, 8'h4D);
    peek_bytes(24'h563412, "R5 read 0x4D after R7 preload");

    // R6 snapshot holds while counting
    repeat (2) pulse(0, 7);
    peek_bytes(24'h563412, "R6 snapshot held");
    read_expect(7, 24'h563414, "R6 new snapshot");

    // R3 / R4 wrap with enable set
    preload(10, 24'hFFFFFE);
    reg_wr(3'd1, 8'h03);
    pulse(0, 10);
    check_irq(1'b0, "R4 no irq before wrap");
    pulse(0, 10);
    check_irq(1'b1, "R3 wrap raises irq");
    read_expect(10, 24'h0, "R3 wrapped to zero");
    check_irq(1'b0, "R5 read clears flag");

    // R4 enable set/clear with sticky flag
    preload(11, 24'hFFFFFF);
    pulse(0, 11);
    check_irq(1'b0, "R4 masked overflow");
    reg_wr(3'd1, 8'h4B);
    check_irq(1'b1, "R4 enable exposes sticky flag");
    reg_wr(3'd1, 8'h0F);
    check_irq(1'b0, "R4 enable clear");
    reg_wr(3'd1, 8'h03);
    check_irq(1'b1, "R4 enable set again");
    read_expect(11, 24'h0, "R4 counter 11");
    check_irq(1'b0, "R4 read clears");

    // R8 load beats same-cycle event
    reg_wr(3'd2, 8'hAA);
    reg_wr(3'd3, 8'hBB);
    reg_wr(3'd4, 8'hCC);
    reg_wr(3'd0, 8'd12);
    @(posedge clk); #1;
    we = 1'b1; addr = 3'd1; wdata = 8'h01; in_ev[12] = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; in_ev = '0;
    read_expect(12, 24'hCCBBAA, "R8 load wins");

    // R9 illegal commands ignored
    repeat (2) pulse(0, 12);
    reg_wr(3'd1, 8'h85);
    reg_wr(3'd1, 8'h25);
    reg_wr(3'd1, 8'h15);
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd1, 8'h06);
    peek_bytes(24'hCCBBAA, "R9 no snapshot on illegal cmd");
    reg_wr(3'd0, 8'd13);
    reg_wr(3'd1, 8'h11);
    reg_wr(3'd1, 8'h21);
    read_expect(13, 24'h0, "R9 no load on illegal cmd");
    read_expect(12, 24'hCCBBAC, "R9 counter 12 intact");
    preload(14, 24'hFFFFFF);
    reg_wr(3'd1, 8'h83);
    reg_wr(3'd1, 8'h13);
    pulse(0, 14);
    check_irq(1'b0, "R9 no enable on illegal cmd");
    read_expect(14, 24'h0, "R9 counter 14 wrapped");

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule